// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial Inner Product Unit

This unit forms the signed inner product of N two's-complement samples with N constant coefficients. It uses no multiplier. The coefficients are fixed at build time. A table holds every subset sum of the coefficients and is computed from the coefficient parameter during elaboration. After a load, the unit processes one bit position of all samples per clock, starting with the least significant bit. The bits at that position, one from each sample, form the address into the table. The entry read out is weighted by its bit position and added into a running sum. At the top bit position, which carries the sign, the entry is subtracted instead.

A client presents all N samples in parallel and raises `load` for one cycle while the unit is idle. `busy` then stays high for B cycles. `done` pulses for one cycle when `result` holds the final value. The result stays on the output until the next accepted load. The unit suits inner-product kernels such as filter taps or one row of a small transform.

Top module: `da_dot_unit`

## Requirements
- R1: After reset, `busy`, `done` and `result` are all zero.
- R2: A `load` sampled high while `busy` is low captures `samples`. Sample i is held in bits [i*B +: B]. `busy` is high from the next cycle for exactly B cycles.
- R3: When `done` is high, `result` equals the sum over i of sample[i]*coef[i], computed as signed values, exactly in B+CW+log2(N) bits. The default coefficients are coef0=23, coef1=-7, coef2=-128 and coef3=90, packed as coef i in COEFS[i*CW +: CW].
- R4: The top bit plane of each sample carries weight -2^(B-1). Negative samples, including -2^(B-1), give the correct signed product.
- R5: `done` goes high for exactly one cycle on the B-th rising edge after the edge that accepted the load. `busy` is low while `done` is high.
- R6: A `load` raised while `busy` is high has no effect. The result and the completion time are those of the operands already accepted.
- R7: After `done`, `result` stays unchanged until the next accepted load, whatever `samples` does.
- R8: Table entry a holds the sum of coef[i] over the bits i set in a. Bit i of the address comes from sample i. A lone sample of value 1 therefore yields exactly its coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Start strobe, accepted only when idle |
| samples | input | N*B | Packed signed samples, sample i at [i*B +: B] |
| busy | output | 1 | High while bit planes are being processed |
| done | output | 1 | One-cycle pulse when result is final |
| result | output | B+CW+log2(N) | Signed inner product |

## Verification
The bench builds the unit with its default parameters: N=4 samples of B=8 bits, 8-bit coefficients and an 18-bit result. One of the default coefficients is -128. The table therefore holds subset sums at both sign extremes, and a sample of -128 multiplies against the most negative coefficient. That case is the largest-magnitude product an 8-bit by 8-bit pair can give. Single-sample inputs of +1 and -1 read the table entries one coefficient at a time. A load raised mid-run tests that the unit ignores a start while busy.

// File: rtl/da_pkg.sv
// Package: shared defaults and width helpers for the distributed-arithmetic
// inner product unit. Assumes all widths are positive.
package da_pkg;
    localparam int DA_N  = 4;   // number of samples
    localparam int DA_B  = 8;   // sample width
    localparam int DA_CW = 8;   // coefficient width

    // Width of a subset sum of n coefficients of width cw
    function automatic int da_table_width(input int cw, input int n);
        return cw + $clog2(n);
    endfunction

    // Width of the full inner product
    function automatic int da_result_width(input int b, input int cw, input int n);
        return b + cw + $clog2(n);
    endfunction
endpackage

// File: rtl/da_coef_rom.sv
// Module: constant table of every subset sum of N signed coefficients.
// Entry a holds the sum of coef[i] for each bit i set in a. The table is
// computed from COEFS at elaboration; the read is combinational.
// Assumes N is small enough for 2**N entries.
module da_coef_rom #(
    parameter int N   = da_pkg::DA_N,
    parameter int CW  = da_pkg::DA_CW,
    parameter int RW  = da_pkg::da_table_width(da_pkg::DA_CW, da_pkg::DA_N),
    parameter logic [N*CW-1:0] COEFS = '0
) (
    input  logic [N-1:0]  addr,
    output logic [RW-1:0] word
);
    localparam int DEPTH = 1 << N;

    // Subset sum of the coefficients selected by the address bits
    function automatic logic [RW-1:0] subset_sum(input logic [N-1:0] a);
        logic [RW-1:0] s;
        logic [CW-1:0] c;
        s = '0;
        for (int i = 0; i < N; i++) begin
            c = COEFS[i*CW +: CW];
            if (a[i]) s = s + {{(RW-CW){c[CW-1]}}, c};
        end
        return s;
    endfunction

    logic [RW-1:0] table_q [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_entry
            // One constant entry per address
            assign table_q[g] = subset_sum(N'(g));
        end
    endgenerate

    // Table lookup
    assign word = table_q[addr];
endmodule

// File: rtl/da_plane_seq.sv
// Module: captures the samples and walks their bit planes from LSB to MSB.
// The sequencer presents one address bit per sample each busy cycle and
// flags the sign plane. A load while busy is ignored. Reset is synchronous
// and active low.
module da_plane_seq #(
    parameter int N  = da_pkg::DA_N,
    parameter int B  = da_pkg::DA_B,
    parameter int IW = $clog2(da_pkg::DA_B)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [N*B-1:0] samples,
    output logic          start,
    output logic          busy,
    output logic          done,
    output logic          sign_plane,
    output logic [IW-1:0] plane_idx,
    output logic [N-1:0]  plane_addr
);
    logic [B-1:0] shreg [N];

    // Accept a load only while idle
    assign start = load && !busy;
    // Current plane is the sign plane at the last index
    assign sign_plane = (plane_idx == IW'(B-1));

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_addr
            // Address bit from the low end of each shift register
            assign plane_addr[g] = shreg[g][0];
        end
    endgenerate

    // Sample shift registers: capture on start, shift right while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) shreg[i] <= '0;
        end else if (start) begin
            for (int i = 0; i < N; i++) shreg[i] <= samples[i*B +: B];
        end else if (busy) begin
            for (int i = 0; i < N; i++) shreg[i] <= shreg[i] >> 1;
        end
    end

    // Plane counter, busy flag and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            plane_idx <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy      <= 1'b1;
                plane_idx <= '0;
            end else if (busy) begin
                if (sign_plane) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    plane_idx <= plane_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/da_shift_acc.sv
// Module: weighted accumulator of table words. Each step adds the word
// shifted left by the plane index. On the sign plane it subtracts the
// word instead. The accumulator is cleared on start. OW must hold the
// full product range.
module da_shift_acc #(
    parameter int RW = da_pkg::da_table_width(da_pkg::DA_CW, da_pkg::DA_N),
    parameter int OW = da_pkg::da_result_width(da_pkg::DA_B, da_pkg::DA_CW, da_pkg::DA_N),
    parameter int IW = $clog2(da_pkg::DA_B)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          sign_plane,
    input  logic [IW-1:0] plane_idx,
    input  logic [RW-1:0] word,
    output logic [OW-1:0] acc
);
    logic signed [OW-1:0] ext;
    logic signed [OW-1:0] term;

    // Sign-extend the table word to the accumulator width
    assign ext  = {{(OW-RW){word[RW-1]}}, word};
    // Weight by bit position
    assign term = ext <<< plane_idx;

    // Accumulate, negating the sign-plane contribution
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (step) begin
            acc <= sign_plane ? (acc - term) : (acc + term);
        end
    end
endmodule

// File: rtl/da_dot_unit.sv
// Module: top of the multiplier-free inner product unit. It connects the
// plane sequencer, the subset-sum table and the shift accumulator. The
// result is final B cycles after an accepted load and is held until the
// next one. Reset is synchronous and active low.
module da_dot_unit #(
    parameter int N  = da_pkg::DA_N,
    parameter int B  = da_pkg::DA_B,
    parameter int CW = da_pkg::DA_CW,
    parameter logic [N*CW-1:0] COEFS = {8'h5A, 8'h80, 8'hF9, 8'h17},
    parameter int OW = da_pkg::da_result_width(B, CW, N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [N*B-1:0] samples,
    output logic          busy,
    output logic          done,
    output logic [OW-1:0] result
);
    localparam int RW = da_pkg::da_table_width(CW, N);
    localparam int IW = (B > 1) ? $clog2(B) : 1;

    logic          start;
    logic          sign_plane;
    logic [IW-1:0] plane_idx;
    logic [N-1:0]  plane_addr;
    logic [RW-1:0] word;

    da_plane_seq #(.N(N), .B(B), .IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .samples    (samples),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .sign_plane (sign_plane),
        .plane_idx  (plane_idx),
        .plane_addr (plane_addr)
    );

    da_coef_rom #(.N(N), .CW(CW), .RW(RW), .COEFS(COEFS)) u_rom (
        .addr (plane_addr),
        .word (word)
    );

    da_shift_acc #(.RW(RW), .OW(OW), .IW(IW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .step       (busy),
        .sign_plane (sign_plane),
        .plane_idx  (plane_idx),
        .word       (word),
        .acc        (result)
    );
endmodule

// File: rtl/da_dot_checker.sv
// Module: protocol and result checker for da_dot_unit, attached by bind.
// It keeps a multiply-based reference of each accepted operand set and
// a counter of the busy run length.
module da_dot_checker #(
    parameter int N  = 4,
    parameter int B  = 8,
    parameter int CW = 8,
    parameter logic [N*CW-1:0] COEFS = '0,
    parameter int OW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load,
    input logic [N*B-1:0] samples,
    input logic          busy,
    input logic          done,
    input logic [OW-1:0] result
);
    // Reference inner product using ordinary multiplication
    function automatic int ref_dot(input logic [N*B-1:0] v);
        int s;
        s = 0;
        for (int i = 0; i < N; i++)
            s = s + int'($signed(v[i*B +: B])) * int'($signed(COEFS[i*CW +: CW]));
        return s;
    endfunction

    int ref_val;
    int run_len;

    // Reference capture on accepted load
    always_ff @(posedge clk) begin
        if (!rst_n) ref_val <= 0;
        else if (load && !busy) ref_val <= ref_dot(samples);
    end

    // Busy run length counter
    always_ff @(posedge clk) begin
        if (!rst_n) run_len <= 0;
        else run_len <= busy ? run_len + 1 : 0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy && !done && result == '0)); // R1
    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (load && !busy) |=> busy); // R2
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (run_len == B)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) done |-> (int'($signed(result)) == ref_val)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R5
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !load && !done) |=> $stable(result)); // R7
endmodule

bind da_dot_unit da_dot_checker #(
    .N(N), .B(B), .CW(CW), .COEFS(COEFS), .OW(OW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .samples (samples),
    .busy    (busy),
    .done    (done),
    .result  (result)
);

// File: tb/da_dot_unit_bench.sv
// Bench: directed scenarios for da_dot_unit, one task per scenario.
module da_dot_unit_bench;
    localparam int N  = 4;
    localparam int B  = 8;
    localparam int OW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [N*B-1:0] samples = '0;
    logic          busy;
    logic          done;
    logic [OW-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    int coef [N] = '{23, -7, -128, 90};

    always #5 clk = ~clk;

    da_dot_unit u_da_dot_unit (
        .clk(clk), .rst_n(rst_n), .load(load), .samples(samples),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [N*B-1:0] pack(input int x0, input int x1,
                                            input int x2, input int x3);
        return {8'(x3), 8'(x2), 8'(x1), 8'(x0)};
    endfunction

    function automatic int model(input int x0, input int x1, input int x2, input int x3);
        return x0*coef[0] + x1*coef[1] + x2*coef[2] + x3*coef[3];
    endfunction

    function automatic int res_int();
        logic signed [OW-1:0] r;
        r = result;
        return int'(r);
    endfunction

    // One computation; optional extra load mid-run with other data
    task automatic run_dot(input int x0, input int x1, input int x2, input int x3,
                           input bit inject, input string req);
        int cnt;
        int exp;
        exp = model(x0, x1, x2, x3);
        @(negedge clk);
        samples = pack(x0, x1, x2, x3);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk(busy == 1'b1, "R2", "busy after load", int'(busy), 1);
        cnt = 1;
        while (!done && cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (inject && cnt == 3) begin
                load = 1'b1;
                samples = pack(-1, 55, 100, -77);
            end else if (inject && cnt == 4) begin
                load = 1'b0;
            end
        end
        // done visible at the B+1-th falling edge after load is raised
        chk(cnt == B + 1, inject ? "R6" : "R5", "done latency", cnt, B + 1);
        chk(busy == 1'b0, "R5", "busy low with done", int'(busy), 0);
        chk(res_int() == exp, req, "result", res_int(), exp);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done at reset", int'(done), 0);
        chk(res_int() == 0, "R1", "result at reset", res_int(), 0);
    endtask

    task automatic t_table();
        run_dot(1, 0, 0, 0, 1'b0, "R8");
        run_dot(0, 1, 0, 0, 1'b0, "R8");
        run_dot(0, 0, 1, 0, 1'b0, "R8");
        run_dot(0, 0, 0, 1, 1'b0, "R8");
        run_dot(1, 1, 1, 1, 1'b0, "R8");
    endtask

    task automatic t_sign();
        run_dot(-1, 0, 0, 0, 1'b0, "R4");
        run_dot(0, 0, -128, 0, 1'b0, "R4");
        run_dot(-128, -128, -128, -128, 1'b0, "R4");
        run_dot(-3, 77, -90, -1, 1'b0, "R4");
    endtask

    task automatic t_general();
        run_dot(0, 0, 0, 0, 1'b0, "R3");
        run_dot(127, 127, 127, 127, 1'b0, "R3");
        run_dot(127, -128, -128, 127, 1'b0, "R3");
        run_dot(-128, 127, 127, -128, 1'b0, "R3");
        run_dot(12, -45, 66, 101, 1'b0, "R3");
    endtask

    task automatic t_ignore();
        run_dot(9, -20, 33, -4, 1'b1, "R6");
    endtask

    task automatic t_hold();
        int held;
        run_dot(50, 60, -70, 80, 1'b0, "R7");
        held = res_int();
        @(negedge clk);
        chk(done == 1'b0, "R5", "done width", int'(done), 0);
        samples = pack(1, 2, 3, 4);
        repeat (6) @(negedge clk);
        chk(res_int() == held, "R7", "result held", res_int(), held);
        chk(busy == 1'b0, "R7", "stays idle", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_table();
        t_sign();
        t_general();
        t_ignore();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule